// File: doc/BRIEF.md
# AUX-to-I2C Transaction Sequencer

This block takes one display-link auxiliary-channel request at a time and breaks it into single-byte operations. A request carries a command code, a 20-bit address, a byte count from 1 to 16 and up to 16 bytes of write data. Native requests go to a local register bus, one byte per access, and the address steps up by one after each byte. I2C-style requests go to a byte-level I2C master that understands four operations: start, stop, write a byte and read a byte. The request finishes with a one-cycle done pulse and a reply bit. Read data is returned in the same 16-byte buffer that held the write data.

The sequencer keeps track of whether the I2C side still holds a transaction open. A plain I2C request always closes the bus when its bytes are done. A request flagged "middle of transaction" (MOT) leaves the bus open afterwards. A later MOT request carries on inside the open transaction, and it begins a new start only when no transaction is open or when its address or command differs from the previous MOT request.

Top module: `aux_i2c_seq`

## Requirements
- R1: The accepted command codes are 4'h0 I2C write, 4'h1 I2C read, 4'h4 I2C write MOT, 4'h5 I2C read MOT, 4'h8 native write and 4'h9 native read. Any other code is answered with NACK and produces no bus operation.
- R2: `reqReady` is high only while idle, and a request is taken when `reqValid` and `reqReady` are both high. Each request ends with `doneValid` high for exactly one cycle. `doneNack` is 0 for ACK and 1 for NACK, and it is ACK only if every byte completed without error. Byte i of `rdData` and `reqWrData` sits at bits 8i+7..8i.
- R3: Native byte i accesses `regAddr` = request address + i, in increasing order. Native writes send buffer byte i. Native reads place the returned byte in `rdData` byte i.
- R4: The first native access answered with `regErr` ends the request with NACK. No further access is made.
- R5: `i2cOp` encodes 0 start, 1 stop, 2 write byte, 3 read byte. A start carries `i2cAddr` = request address bits 6..0 and `i2cRnw` = 1 for reads. Every register-bus or I2C command is held unchanged until its acknowledge, and the next command waits for that acknowledge.
- R6: A plain I2C request first issues a stop if a transaction is open, then a start, then its bytes, then always a stop. A start is never issued while a transaction is open.
- R7: A start answered with `i2cErr` ends the request at once with NACK, with no byte operations and no stop.
- R8: An MOT request issues a start when nothing is open. It issues a stop and then a start when a transaction is open but the full 20-bit address or the command differs from those of the previous accepted MOT request. Otherwise it issues no start.
- R9: A successful MOT request ends with no stop and leaves the transaction open. Its address and command become the reference for the next MOT request.
- R10: A data byte answered with `i2cErr`, in a plain or an MOT request, is followed by a stop and a NACK reply.
- R11: Synchronous reset returns the block to idle with no transaction open, so the next MOT request starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqCmd | input | 4 | Command code |
| reqAddr | input | 20 | Register address or I2C target address |
| reqLen | input | 5 | Byte count, 1 to 16 |
| reqWrData | input | 128 | Write data buffer, byte i at bits 8i+7..8i |
| doneValid | output | 1 | One-cycle completion pulse |
| doneNack | output | 1 | Reply: 0 ACK, 1 NACK |
| rdData | output | 128 | Read data buffer |
| regReq | output | 1 | Register-bus byte access request |
| regWe | output | 1 | Register-bus write enable |
| regAddr | output | 20 | Register-bus byte address |
| regWdata | output | 8 | Register-bus write byte |
| regAck | input | 1 | Register-bus access done |
| regErr | input | 1 | Register-bus access failed, valid with regAck |
| regRdata | input | 8 | Register-bus read byte, valid with regAck |
| i2cReq | output | 1 | I2C master command request |
| i2cOp | output | 2 | I2C operation code |
| i2cAddr | output | 7 | I2C target address for start |
| i2cRnw | output | 1 | Direction for start, 1 read |
| i2cWdata | output | 8 | Byte to write |
| i2cAck | input | 1 | I2C command done |
| i2cErr | input | 1 | I2C command failed, valid with i2cAck |
| i2cRdata | input | 8 | Byte read, valid with i2cAck |

## Verification
The assertions take for granted that the byte count of every accepted request lies between 1 and 16. They also assume that both bus agents answer each request with a single-cycle acknowledge and that the error and read-data inputs are valid in that cycle. The bench agents reply one cycle after they see a request and drop the acknowledge on the next cycle, so no acknowledge is ever held over into the following command. Every request the bench drives uses a legal length. Illegal command codes are sent on purpose only to check the NACK reply.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2cOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;
    logic byteNext;
    logic setOpen;
    logic clrOpen;
    logic saveLast;
  } seqStrobe_t;

endpackage

// File: rtl/aux_seq_dp.sv
module aux_seq_dp
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW  = 7,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  seqStrobe_t             stb,
  input  logic [3:0]             reqCmd,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic [MAX_LEN*8-1:0]   reqWrData,
  input  logic [7:0]             regRdata,
  input  logic [7:0]             i2cRdata,
  output logic                   cmdValid,
  output logic                   isNative,
  output logic                   isMot,
  output logic                   isRead,
  output logic                   openFlag,
  output logic                   lastMatch,
  output logic                   lastByte,
  output logic [ADDR_W-1:0]      curAddr,
  output logic [7:0]             curByte,
  output logic [I2C_AW-1:0]      i2cAddr,
  output logic [MAX_LEN*8-1:0]   rdData
);

  logic [3:0]        cmdReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [LEN_W-1:0]  lenReg;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] lastAddr;
  logic [3:0]        lastCmd;
  logic [7:0]        bufMem [MAX_LEN];
  logic [7:0]        rdByte;

  always_comb begin
    cmdValid = 1'b1;
    isNative = 1'b0;
    isMot    = 1'b0;
    isRead   = 1'b0;
    case (cmdReg)
      CMD_I2C_WR: ;
      CMD_I2C_RD: isRead = 1'b1;
      CMD_MOT_WR: isMot = 1'b1;
      CMD_MOT_RD: begin isMot = 1'b1; isRead = 1'b1; end
      CMD_NAT_WR: isNative = 1'b1;
      CMD_NAT_RD: begin isNative = 1'b1; isRead = 1'b1; end
      default:    cmdValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg   <= 4'hF;
      baseAddr <= '0;
      lenReg   <= '0;
      idx      <= '0;
      openFlag <= 1'b0;
      lastAddr <= '0;
      lastCmd  <= 4'hF;
    end else begin
      if (stb.loadReq) begin
        cmdReg   <= reqCmd;
        baseAddr <= reqAddr;
        lenReg   <= reqLen;
        idx      <= '0;
      end else if (stb.byteNext) begin
        idx <= idx + 1'b1;
      end
      if (stb.setOpen)      openFlag <= 1'b1;
      else if (stb.clrOpen) openFlag <= 1'b0;
      if (stb.saveLast) begin
        lastAddr <= baseAddr;
        lastCmd  <= cmdReg;
      end
    end
  end

  assign rdByte = isNative ? regRdata : i2cRdata;

  for (genvar g = 0; g < MAX_LEN; g++) begin : gBuf
    always_ff @(posedge clk) begin
      if (rst)
        bufMem[g] <= '0;
      else if (stb.loadReq)
        bufMem[g] <= reqWrData[8*g +: 8];
      else if (stb.byteNext && isRead && idx == IDX_W'(g))
        bufMem[g] <= rdByte;
    end
    assign rdData[8*g +: 8] = bufMem[g];
  end

  assign curAddr   = baseAddr + ADDR_W'(idx);
  assign curByte   = bufMem[idx];
  assign i2cAddr   = baseAddr[I2C_AW-1:0];
  assign lastByte  = (LEN_W'(idx) == lenReg - LEN_W'(1));
  assign lastMatch = (baseAddr == lastAddr) && (cmdReg == lastCmd);

  // R2: input assumption on the byte count
  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    stb.loadReq |-> (reqLen >= LEN_W'(1) && reqLen <= LEN_W'(MAX_LEN)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.byteNext && !lastByte) |=> (curAddr == $past(curAddr) + ADDR_W'(1)));

endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
  import aux_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       doneValid,
  output logic       doneNack,
  input  logic       cmdValid,
  input  logic       isNative,
  input  logic       isMot,
  input  logic       isRead,
  input  logic       openFlag,
  input  logic       lastMatch,
  input  logic       lastByte,
  output logic       regReq,
  output logic       regWe,
  input  logic       regAck,
  input  logic       regErr,
  output logic       i2cReq,
  output i2cOp_e     i2cOp,
  input  logic       i2cAck,
  input  logic       i2cErr,
  output seqStrobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_NAT, ST_PRESTOP, ST_START, ST_BYTE, ST_POSTSTOP, ST_DONE
  } seqState_e;

  seqState_e state, nextState;
  logic      nackReg, nackNext;

  always_comb begin
    nextState = state;
    nackNext  = nackReg;
    stb       = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1;
        nackNext    = 1'b0;
        nextState   = ST_DECODE;
      end
      ST_DECODE: begin
        if (!cmdValid) begin
          nackNext  = 1'b1;
          nextState = ST_DONE;
        end else if (isNative) begin
          nextState = ST_NAT;
        end else if (isMot) begin
          if (!openFlag)
            nextState = ST_START;
          else if (!lastMatch)
            nextState = ST_PRESTOP;
          else begin
            stb.saveLast = 1'b1;
            nextState    = ST_BYTE;
          end
        end else begin
          nextState = openFlag ? ST_PRESTOP : ST_START;
        end
      end
      ST_NAT: if (regAck) begin
        if (regErr) begin
          nackNext  = 1'b1;
          nextState = ST_DONE;
        end else begin
          stb.byteNext = 1'b1;
          if (lastByte) nextState = ST_DONE;
        end
      end
      ST_PRESTOP: if (i2cAck) begin
        stb.clrOpen = 1'b1;
        nextState   = ST_START;
      end
      ST_START: if (i2cAck) begin
        if (i2cErr) begin
          nackNext  = 1'b1;
          nextState = ST_DONE;
        end else begin
          stb.setOpen  = 1'b1;
          stb.saveLast = isMot;
          nextState    = ST_BYTE;
        end
      end
      ST_BYTE: if (i2cAck) begin
        if (i2cErr) begin
          nackNext  = 1'b1;
          nextState = ST_POSTSTOP;
        end else begin
          stb.byteNext = 1'b1;
          if (lastByte) nextState = isMot ? ST_DONE : ST_POSTSTOP;
        end
      end
      ST_POSTSTOP: if (i2cAck) begin
        stb.clrOpen = 1'b1;
        nextState   = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nackReg <= 1'b0;
    end else begin
      state   <= nextState;
      nackReg <= nackNext;
    end
  end

  always_comb begin
    case (state)
      ST_START: i2cOp = OP_START;
      ST_BYTE:  i2cOp = isRead ? OP_READ : OP_WRITE;
      default:  i2cOp = OP_STOP;
    endcase
  end

  assign i2cReq    = (state == ST_PRESTOP) || (state == ST_START) ||
                     (state == ST_BYTE) || (state == ST_POSTSTOP);
  assign regReq    = (state == ST_NAT);
  assign regWe     = !isRead;
  assign reqReady  = (state == ST_IDLE);
  assign doneValid = (state == ST_DONE);
  assign doneNack  = nackReg;

  // R5
  i2c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (i2cReq && !i2cAck) |=> (i2cReq && $stable(i2cOp)));

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (regReq && !regAck) |=> (regReq && $stable(regWe)));

  // R6
  start_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (i2cReq && i2cOp == OP_START) |-> !openFlag);

  // R8
  open_set_chk: assert property (@(posedge clk) disable iff (rst)
    (i2cReq && i2cAck && !i2cErr && i2cOp == OP_START) |=> openFlag);

  // R10
  stop_close_chk: assert property (@(posedge clk) disable iff (rst)
    (i2cReq && i2cAck && i2cOp == OP_STOP) |=> !openFlag);

  // R9
  mot_open_chk: assert property (@(posedge clk) disable iff (rst)
    (doneValid && isMot && !doneNack) |-> openFlag);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

endmodule

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW  = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [3:0]           reqCmd,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [MAX_LEN*8-1:0] reqWrData,
  output logic                 doneValid,
  output logic                 doneNack,
  output logic [MAX_LEN*8-1:0] rdData,
  output logic                 regReq,
  output logic                 regWe,
  output logic [ADDR_W-1:0]    regAddr,
  output logic [7:0]           regWdata,
  input  logic                 regAck,
  input  logic                 regErr,
  input  logic [7:0]           regRdata,
  output logic                 i2cReq,
  output logic [1:0]           i2cOp,
  output logic [I2C_AW-1:0]    i2cAddr,
  output logic                 i2cRnw,
  output logic [7:0]           i2cWdata,
  input  logic                 i2cAck,
  input  logic                 i2cErr,
  input  logic [7:0]           i2cRdata
);

  seqStrobe_t        stb;
  logic              cmdValid, isNative, isMot, isRead;
  logic              openFlag, lastMatch, lastByte;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        curByte;
  i2cOp_e            opCode;

  aux_seq_dp #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .I2C_AW(I2C_AW)) uDp (
    .clk(clk), .rst(rst), .stb(stb),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqLen(reqLen), .reqWrData(reqWrData),
    .regRdata(regRdata), .i2cRdata(i2cRdata),
    .cmdValid(cmdValid), .isNative(isNative), .isMot(isMot), .isRead(isRead),
    .openFlag(openFlag), .lastMatch(lastMatch), .lastByte(lastByte),
    .curAddr(curAddr), .curByte(curByte), .i2cAddr(i2cAddr), .rdData(rdData)
  );

  aux_seq_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqReady(reqReady),
    .doneValid(doneValid), .doneNack(doneNack),
    .cmdValid(cmdValid), .isNative(isNative), .isMot(isMot), .isRead(isRead),
    .openFlag(openFlag), .lastMatch(lastMatch), .lastByte(lastByte),
    .regReq(regReq), .regWe(regWe), .regAck(regAck), .regErr(regErr),
    .i2cReq(i2cReq), .i2cOp(opCode), .i2cAck(i2cAck), .i2cErr(i2cErr),
    .stb(stb)
  );

  assign i2cOp    = opCode;
  assign i2cRnw   = isRead;
  assign i2cWdata = curByte;
  assign regAddr  = curAddr;
  assign regWdata = curByte;

endmodule

// File: tb/tb_aux_i2c_seq.sv
module tb_aux_i2c_seq;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqCmd = '0;
  logic [19:0]  reqAddr = '0;
  logic [4:0]   reqLen = 5'd1;
  logic [127:0] reqWrData = '0;
  logic         doneValid, doneNack;
  logic [127:0] rdData;
  logic         regReq, regWe;
  logic [19:0]  regAddr;
  logic [7:0]   regWdata;
  logic         regAck = 1'b0, regErr = 1'b0;
  logic [7:0]   regRdata = '0;
  logic         i2cReq;
  logic [1:0]   i2cOp;
  logic [6:0]   i2cAddr;
  logic         i2cRnw;
  logic [7:0]   i2cWdata;
  logic         i2cAck = 1'b0, i2cErr = 1'b0;
  logic [7:0]   i2cRdata = '0;

  always #5 clk = ~clk;

  aux_i2c_seq dut (.*);

  int nChecks = 0, nFails = 0, doneCnt = 0;
  logic [35:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  devMem  [256];
  logic [7:0]  predMem [256];
  logic [7:0]  rdSeq = 8'd0, predRdSeq = 8'd0;
  logic        predOpen = 1'b0;
  logic [19:0] predLastA = '0;
  logic [3:0]  predLastC = 4'hF;

  function automatic logic [35:0] mk(input logic [3:0] k, input logic [31:0] p);
    return {k, p};
  endfunction

  task automatic push(input logic [35:0] it, input string tag);
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  task automatic checkItem(input logic [35:0] act);
    logic [35:0] e;
    string t;
    nChecks++;
    if (expQ.size() == 0) begin
      nFails++;
      $display("FAIL R2 unexpected item act=%h exp=none", act);
    end else begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      if (act !== e) begin
        nFails++;
        $display("FAIL %s act=%h exp=%h", t, act, e);
      end
    end
  endtask

  // bus agents and monitor
  always @(negedge clk) begin
    if (rst) begin
      i2cAck = 1'b0;
      regAck = 1'b0;
    end else begin
      if (i2cAck) i2cAck = 1'b0;
      else if (i2cReq) begin
        i2cErr = 1'b0;
        case (i2cOp)
          2'd0: begin
            checkItem(mk(4'd1, {24'd0, i2cRnw, i2cAddr}));
            i2cErr = (i2cAddr == 7'h33);
          end
          2'd1: checkItem(mk(4'd2, 32'd0));
          2'd2: begin
            checkItem(mk(4'd3, {24'd0, i2cWdata}));
            i2cErr = (i2cWdata == 8'hEE);
          end
          default: begin
            checkItem(mk(4'd4, 32'd0));
            i2cRdata = 8'h5A ^ rdSeq;
            rdSeq    = rdSeq + 8'd1;
          end
        endcase
        i2cAck = 1'b1;
      end
      if (regAck) regAck = 1'b0;
      else if (regReq) begin
        regErr = (regAddr[19:12] == 8'hFF);
        if (regWe) begin
          checkItem(mk(4'd5, {4'd0, regAddr, regWdata}));
          if (!regErr) devMem[regAddr[7:0]] = regWdata;
        end else begin
          checkItem(mk(4'd6, {12'd0, regAddr}));
          regRdata = devMem[regAddr[7:0]];
        end
        regAck = 1'b1;
      end
      if (doneValid) begin
        checkItem(mk(4'd7, {31'd0, doneNack}));
        doneCnt++;
      end
    end
  end

  task automatic runReq(input logic [3:0] cmd, input logic [19:0] addr,
                        input int len, input logic [127:0] wd, input string tag);
    logic         nack, fail, restart;
    logic [127:0] expRd;
    logic [19:0]  a;
    logic [7:0]   b;
    int           target;
    nack  = 1'b0;
    expRd = '0;
    case (cmd)
      4'h8, 4'h9: begin
        for (int i = 0; i < len; i++) begin
          a = addr + 20'(i);
          b = wd[8*i +: 8];
          if (cmd == 4'h8) push(mk(4'd5, {4'd0, a, b}), "R3");
          else             push(mk(4'd6, {12'd0, a}), "R3");
          if (a[19:12] == 8'hFF) begin nack = 1'b1; break; end
          if (cmd == 4'h8) predMem[a[7:0]] = b;
          else             expRd[8*i +: 8] = predMem[a[7:0]];
        end
        if (nack) tag = "R4";
      end
      4'h0, 4'h1, 4'h4, 4'h5: begin
        if (cmd[2]) begin
          restart = !predOpen || addr != predLastA || cmd != predLastC;
          if (restart && predOpen) push(mk(4'd2, 32'd0), "R8");
          if (restart) begin
            predOpen = 1'b0;
            push(mk(4'd1, {24'd0, cmd[0], addr[6:0]}), "R8");
          end
        end else begin
          restart = 1'b1;
          if (predOpen) push(mk(4'd2, 32'd0), "R6");
          predOpen = 1'b0;
          push(mk(4'd1, {24'd0, cmd[0], addr[6:0]}), "R6");
        end
        fail = restart && (addr[6:0] == 7'h33);
        if (fail) begin
          nack = 1'b1;
          tag  = "R7";
        end else begin
          predOpen = 1'b1;
          if (cmd[2]) begin predLastA = addr; predLastC = cmd; end
          for (int i = 0; i < len; i++) begin
            b = wd[8*i +: 8];
            if (!cmd[0]) begin
              push(mk(4'd3, {24'd0, b}), "R5");
              if (b == 8'hEE) begin nack = 1'b1; break; end
            end else begin
              push(mk(4'd4, 32'd0), "R5");
              expRd[8*i +: 8] = 8'h5A ^ predRdSeq;
              predRdSeq = predRdSeq + 8'd1;
            end
          end
          if (nack || !cmd[2]) begin
            push(mk(4'd2, 32'd0), nack ? "R10" : "R6");
            predOpen = 1'b0;
          end
          if (nack) tag = "R10";
        end
      end
      default: begin nack = 1'b1; tag = "R1"; end
    endcase
    push(mk(4'd7, {31'd0, nack}), tag);

    target = doneCnt + 1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqCmd    = cmd;
    reqAddr   = addr;
    reqLen    = 5'(len);
    reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (doneCnt < target) @(negedge clk);

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL %s missing items act=%0d exp=0", tag, expQ.size());
      expQ.delete();
      tagQ.delete();
    end
    if (cmd inside {4'h1, 4'h5, 4'h9} && !nack) begin
      nChecks++;
      for (int i = 0; i < len; i++) begin
        if (rdData[8*i +: 8] !== expRd[8*i +: 8]) begin
          nFails++;
          $display("FAIL R3 read byte %0d act=%h exp=%h", i, rdData[8*i +: 8], expRd[8*i +: 8]);
          break;
        end
      end
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    predOpen  = 1'b0;
    predLastC = 4'hF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      devMem[i]  = 8'(i * 3);
      predMem[i] = 8'(i * 3);
    end
    doReset();
    @(negedge clk);
    // R11 reset state
    nChecks++;
    if (!(reqReady === 1'b1 && doneValid === 1'b0 && i2cReq === 1'b0 && regReq === 1'b0)) begin
      nFails++;
      $display("FAIL R11 reset act=%b%b%b%b exp=1000", reqReady, doneValid, i2cReq, regReq);
    end

    // native write/read, incl. full length
    runReq(4'h8, 20'h00010, 4, 128'h44332211, "R3");
    runReq(4'h9, 20'h00010, 4, '0, "R3");
    runReq(4'h8, 20'h00020, 16, 128'hF0E0D0C0B0A090807060504030201000, "R3");
    runReq(4'h9, 20'h0001E, 16, '0, "R3");
    // native error part way
    runReq(4'h9, 20'hFEFFF, 3, '0, "R4");
    // illegal commands
    runReq(4'h3, 20'h00050, 2, '0, "R1");
    runReq(4'hC, 20'h00050, 1, '0, "R1");
    // plain I2C
    runReq(4'h0, 20'h00050, 2, 128'hBBAA, "R6");
    runReq(4'h1, 20'h00050, 3, '0, "R6");
    runReq(4'h0, 20'h00033, 2, 128'h0102, "R7");
    // MOT continuation and restarts
    runReq(4'h4, 20'h00050, 1, 128'h11, "R8");
    runReq(4'h4, 20'h00050, 2, 128'h3322, "R9");
    runReq(4'h5, 20'h00050, 2, '0, "R8");
    runReq(4'h5, 20'h00051, 1, '0, "R8");
    runReq(4'h5, 20'h10051, 1, '0, "R8");
    runReq(4'h5, 20'h10051, 2, '0, "R9");
    runReq(4'h0, 20'h00050, 1, 128'h77, "R6");
    // byte errors
    runReq(4'h4, 20'h00050, 3, 128'h55EE44, "R10");
    runReq(4'h4, 20'h00050, 1, 128'h66, "R8");
    runReq(4'h0, 20'h00052, 2, 128'hEE01, "R10");
    // start failure while open
    runReq(4'h4, 20'h00050, 1, 128'h12, "R9");
    runReq(4'h4, 20'h00033, 1, 128'h12, "R7");
    runReq(4'h4, 20'h00033, 1, 128'h12, "R7");
    runReq(4'h4, 20'h00050, 1, 128'h13, "R8");
    // reset closes the open transaction (R11)
    doReset();
    runReq(4'h4, 20'h00050, 1, 128'h14, "R11");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule